// File: doc/BRIEF.md
# Asynchronous Serial Character Receiver

This block recovers characters from an asynchronous serial line. A sampling enable pulses at sixteen times the bit rate. The block uses it to find the start of each character, to decide every bit by a three-sample vote near the bit centre, and to check the parity and stop bits of the frame. Each character it receives leaves the block as a 16-bit word on a valid/ready output. The word packs the received byte together with error, break, overrun and summary flags.

The character length (7 or 8 bits), the parity mode (off, even or odd), the number of stop bits (1 or 2) and an input inversion are static configuration inputs. Change them only while the line is idle. Two outputs report the line state. The first shows whether a character is in progress. The second flags an idle line once a selectable number of whole frame times has passed since the last character. The block holds one character at its output. A character that arrives while that slot is still occupied is dropped, and the loss is recorded in the next character that is delivered.

Top module: `serial_rx_unit`

## Requirements
- R1: `out_word` carries the received data in bits 7:0, parity error in bit 10, break in bit 11, framing error in bit 12, overrun in bit 13, the summary error in bit 14, and a copy of `out_valid` in bit 15. Bits 9:8 are always 0.
- R2: With `cfg_len8`=1 a character has 8 data bits. With `cfg_len8`=0 it has 7 data bits and bit 7 of the word reads 0. Data bits arrive least significant bit first, after one low start bit.
- R3: With `cfg_par_en`=1 a parity bit follows the data. It gives an even count of ones over data plus parity when `cfg_par_odd`=0, and an odd count when `cfg_par_odd`=1. A mismatch sets bit 10. With `cfg_par_en`=0 no parity bit is expected and bit 10 stays 0.
- R4: The first stop bit must read high. With `cfg_two_stop`=1 the second stop bit must also read high. A low stop bit sets bit 12, and the receiver then waits for a high line before it looks for a new start bit.
- R5: If the data bits, the parity bit (when enabled) and the first stop bit all read low, bit 11 (break) and bit 12 are both set and the data field is 0.
- R6: Bit 14 is the OR of bits 10, 11, 12 and 13 of the same word.
- R7: A character that completes while `out_valid`=1 and `out_ready`=0 is discarded. The next character placed on the output then has bit 13 and bit 14 set.
- R8: While `out_valid`=1 and `out_ready`=0, `out_valid` stays 1 and `out_word` does not change.
- R9: A start bit is accepted only when the line reads low on a sampling enable. A low pulse shorter than half a bit that reads high at mid-bit is rejected and produces no character.
- R10: With `cfg_rx_invert`=1 the `rxd` input is inverted before any sampling. Idle is then low on the pin, and characters decode as with a non-inverted line.
- R11: `line_idle` is 1 while the receiver is hunting for a start bit and 0 while a character is being received.
- R12: `idle_hit` rises after a character once the line has stayed idle for (4 << `cfg_idle_sel`) frame times, that is 4, 8, 16 or 32 frames for codes 0 to 3. One frame time is (1 + data bits + parity bit + stop bits) × 16 sampling enables. It clears when a new start bit is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | Sampling enable, 16 pulses per bit time |
| rxd | input | 1 | Serial data line |
| cfg_len8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfg_par_en | input | 1 | Parity bit present and checked |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| cfg_two_stop | input | 1 | 1: two stop bits required |
| cfg_idle_sel | input | 2 | Idle threshold code: 4, 8, 16 or 32 frames |
| cfg_rx_invert | input | 1 | Invert the line before sampling |
| out_valid | output | 1 | Character word available |
| out_ready | input | 1 | Consumer accepts the word |
| out_word | output | 16 | Data byte and status flags |
| line_idle | output | 1 | No character reception in progress |
| idle_hit | output | 1 | Line idle for the selected number of frames |

## Verification
The bench builds the block with its defaults: 16 samples per bit, a two-stage input synchronizer and a 14-bit idle counter. It pulses the sampling enable every fourth clock. With these values a bit lasts 64 clocks, so well over a hundred random frames fit in the run, covering every length, parity and stop-bit combination with and without inversion. The 4-frame and 8-frame idle thresholds are also within reach, which is enough to check the frame-length arithmetic in the threshold against two codes. Directed cases cover break, overrun with a stalled consumer, the short-pulse glitch and a missing second stop bit.

// File: rtl/srx_pkg.sv
package srx_pkg;

    localparam int DATA_W   = 8;
    localparam int WORD_W   = 16;

    // Field positions of the delivered character word
    localparam int POS_PERR = 10;
    localparam int POS_BRK  = 11;
    localparam int POS_FERR = 12;
    localparam int POS_OVR  = 13;
    localparam int POS_ERR  = 14;

    typedef enum logic [2:0] {
        S_HUNT,
        S_START,
        S_DATA,
        S_PAR,
        S_STOP1,
        S_STOP2,
        S_WAITHI
    } rx_state_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              par_err;
        logic              brk;
        logic              frm_err;
    } rx_char_t;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    // Bits in one frame: start + data + optional parity + stop(s)
    function automatic int unsigned frame_bits(input logic len8, input logic par,
                                               input logic two);
        return 32'd9 + 32'(len8) + 32'(par) + 32'(two);
    endfunction

    function automatic int unsigned idle_ticks(input logic [1:0] sel, input logic len8,
                                               input logic par, input logic two,
                                               input int unsigned os_rate);
        return (32'd4 << sel) * frame_bits(len8, par, two) * os_rate;
    endfunction

    function automatic logic [WORD_W-2:0] pack_body(input rx_char_t c, input logic ovr);
        logic [WORD_W-2:0] b;
        b                 = '0;
        b[DATA_W-1:0]     = c.data;
        b[POS_PERR]       = c.par_err;
        b[POS_BRK]        = c.brk;
        b[POS_FERR]       = c.frm_err;
        b[POS_OVR]        = ovr;
        b[POS_ERR]        = c.par_err | c.brk | c.frm_err | ovr;
        return b;
    endfunction

endpackage

// File: rtl/srx_line_in.sv
module srx_line_in #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rxd_pin,
    input  logic invert,
    output logic rx_bit
);

    logic [SYNC_STAGES-1:0] sync_q;

    // Inversion sits ahead of the synchronizer so every sample sees the corrected level
    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], rxd_pin ^ invert};
        end
    end

    assign rx_bit = sync_q[SYNC_STAGES-1];

endmodule

// File: rtl/srx_framer.sv
module srx_framer
    import srx_pkg::*;
#(
    parameter int OS_RATE = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     rx_bit,
    input  logic     cfg_len8,
    input  logic     cfg_par_en,
    input  logic     cfg_par_odd,
    input  logic     cfg_two_stop,
    output logic     char_done,
    output rx_char_t char_out,
    output logic     line_idle
);

    localparam int CNT_W = $clog2(OS_RATE);
    localparam int MID   = OS_RATE / 2;
    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] SMP_FIRST = CNT_W'(MID - 1);
    localparam logic [CNT_W-1:0] SMP_LAST  = CNT_W'(MID + 1);
    localparam logic [CNT_W-1:0] CNT_TOP   = CNT_W'(OS_RATE - 1);
    localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);

    rx_state_t         st;
    logic [CNT_W-1:0]  cnt;
    logic [1:0]        votes;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] data_r;
    logic              par_r;
    logic              done_r;
    rx_char_t          char_r;

    logic              in_bit;
    logic              vote;
    logic              at_mid;
    logic              at_end;
    logic [IDX_W-1:0]  last_idx;
    logic              data_zero;
    logic              par_bad;

    always_comb begin
        in_bit    = (st == S_START) || (st == S_DATA) || (st == S_PAR) ||
                    (st == S_STOP1) || (st == S_STOP2);
        vote      = maj3(votes[1], votes[0], rx_bit);
        at_mid    = tick && in_bit && (cnt == SMP_LAST);
        at_end    = tick && in_bit && (cnt == CNT_TOP);
        last_idx  = cfg_len8 ? IDX_W'(DATA_W - 1) : IDX_W'(DATA_W - 2);
        data_zero = (data_r == '0);
        par_bad   = cfg_par_en && (^data_r ^ par_r ^ cfg_par_odd);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_HUNT;
            cnt    <= '0;
            votes  <= '0;
            idx    <= '0;
            data_r <= '0;
            par_r  <= 1'b0;
            done_r <= 1'b0;
            char_r <= '0;
        end else begin
            done_r <= 1'b0;
            if (tick && in_bit) begin
                if (cnt >= SMP_FIRST && cnt <= SMP_LAST) begin
                    votes <= {votes[0], rx_bit};
                end
                cnt <= (cnt == CNT_TOP) ? '0 : cnt + CNT_ONE;
            end
            case (st)
                S_HUNT: begin
                    if (tick && !rx_bit) begin
                        st     <= S_START;
                        cnt    <= CNT_ONE;
                        idx    <= '0;
                        data_r <= '0;
                        par_r  <= 1'b0;
                    end
                end
                S_START: begin
                    if (at_mid && vote) begin
                        st <= S_HUNT;
                    end else if (at_end) begin
                        st <= S_DATA;
                    end
                end
                S_DATA: begin
                    if (at_mid) begin
                        data_r[idx] <= vote;
                    end
                    if (at_end) begin
                        if (idx == last_idx) begin
                            st <= cfg_par_en ? S_PAR : S_STOP1;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                S_PAR: begin
                    if (at_mid) begin
                        par_r <= vote;
                    end
                    if (at_end) begin
                        st <= S_STOP1;
                    end
                end
                S_STOP1: begin
                    if (at_mid) begin
                        if (!vote) begin
                            done_r <= 1'b1;
                            char_r <= '{data: data_r, par_err: par_bad,
                                        brk: data_zero && (!cfg_par_en || !par_r),
                                        frm_err: 1'b1};
                            st     <= S_WAITHI;
                        end else if (!cfg_two_stop) begin
                            done_r <= 1'b1;
                            char_r <= '{data: data_r, par_err: par_bad,
                                        brk: 1'b0, frm_err: 1'b0};
                            st     <= S_HUNT;
                        end
                    end else if (at_end) begin
                        st <= S_STOP2;
                    end
                end
                S_STOP2: begin
                    if (at_mid) begin
                        done_r <= 1'b1;
                        char_r <= '{data: data_r, par_err: par_bad,
                                    brk: 1'b0, frm_err: !vote};
                        st     <= vote ? S_HUNT : S_WAITHI;
                    end
                end
                S_WAITHI: begin
                    if (tick && rx_bit) begin
                        st <= S_HUNT;
                    end
                end
                default: st <= S_HUNT;
            endcase
        end
    end

    assign char_done = done_r;
    assign char_out  = char_r;
    assign line_idle = (st == S_HUNT);

    // R9
    start_on_low_chk: assert property (@(posedge clk) disable iff (rst)
        (st == S_HUNT && tick && rx_bit) |=> (st == S_HUNT));

    // R5
    brk_implies_frm_chk: assert property (@(posedge clk) disable iff (rst)
        (done_r && char_r.brk) |-> (char_r.frm_err && char_r.data == '0));

    // R2
    short_char_chk: assert property (@(posedge clk) disable iff (rst)
        (done_r && !cfg_len8) |-> !char_r.data[DATA_W-1]);

endmodule

// File: rtl/srx_idle_watch.sv
module srx_idle_watch
    import srx_pkg::*;
#(
    parameter int OS_RATE = 16,
    parameter int CNT_W   = 14
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       line_idle,
    input  logic       char_done,
    input  logic [1:0] cfg_idle_sel,
    input  logic       cfg_len8,
    input  logic       cfg_par_en,
    input  logic       cfg_two_stop,
    output logic       idle_hit
);

    logic             armed;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;

    always_comb begin
        limit = CNT_W'(idle_ticks(cfg_idle_sel, cfg_len8, cfg_par_en, cfg_two_stop,
                                  32'(OS_RATE)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed    <= 1'b0;
            cnt      <= '0;
            idle_hit <= 1'b0;
        end else begin
            if (!line_idle) begin
                cnt      <= '0;
                idle_hit <= 1'b0;
            end else if (armed && tick) begin
                if (cnt == limit - 1'b1) begin
                    idle_hit <= 1'b1;
                    armed    <= 1'b0;
                    cnt      <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
            if (char_done) begin
                armed <= 1'b1;
            end
        end
    end

    // R12
    idle_clears_on_rx_chk: assert property (@(posedge clk) disable iff (rst)
        !line_idle |=> !idle_hit);

endmodule

// File: rtl/srx_out_slot.sv
module srx_out_slot
    import srx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              char_done,
    input  rx_char_t          char_in,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_word
);

    logic              valid_r;
    logic              pend_ovr;
    logic [WORD_W-2:0] body_r;
    logic              take;

    assign take = char_done && (!valid_r || out_ready);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_r  <= 1'b0;
            pend_ovr <= 1'b0;
            body_r   <= '0;
        end else begin
            if (take) begin
                valid_r  <= 1'b1;
                body_r   <= pack_body(char_in, pend_ovr);
                pend_ovr <= 1'b0;
            end else begin
                if (char_done) begin
                    pend_ovr <= 1'b1;
                end
                if (valid_r && out_ready) begin
                    valid_r <= 1'b0;
                end
            end
        end
    end

    assign out_valid = valid_r;
    assign out_word  = {valid_r, body_r};

    // R8
    hold_while_stalled_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));

endmodule

// File: rtl/serial_rx_unit.sv
module serial_rx_unit
    import srx_pkg::*;
#(
    parameter int OS_RATE     = 16,
    parameter int SYNC_STAGES = 2,
    parameter int IDLE_CNT_W  = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              os_tick,
    input  logic              rxd,
    input  logic              cfg_len8,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_two_stop,
    input  logic [1:0]        cfg_idle_sel,
    input  logic              cfg_rx_invert,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_word,
    output logic              line_idle,
    output logic              idle_hit
);

    logic     rx_bit;
    logic     char_done;
    rx_char_t char_data;

    srx_line_in #(.SYNC_STAGES(SYNC_STAGES)) u_line_in (
        .clk     (clk),
        .rst     (rst),
        .rxd_pin (rxd),
        .invert  (cfg_rx_invert),
        .rx_bit  (rx_bit)
    );

    srx_framer #(.OS_RATE(OS_RATE)) u_framer (
        .clk          (clk),
        .rst          (rst),
        .tick         (os_tick),
        .rx_bit       (rx_bit),
        .cfg_len8     (cfg_len8),
        .cfg_par_en   (cfg_par_en),
        .cfg_par_odd  (cfg_par_odd),
        .cfg_two_stop (cfg_two_stop),
        .char_done    (char_done),
        .char_out     (char_data),
        .line_idle    (line_idle)
    );

    srx_idle_watch #(.OS_RATE(OS_RATE), .CNT_W(IDLE_CNT_W)) u_idle (
        .clk          (clk),
        .rst          (rst),
        .tick         (os_tick),
        .line_idle    (line_idle),
        .char_done    (char_done),
        .cfg_idle_sel (cfg_idle_sel),
        .cfg_len8     (cfg_len8),
        .cfg_par_en   (cfg_par_en),
        .cfg_two_stop (cfg_two_stop),
        .idle_hit     (idle_hit)
    );

    srx_out_slot u_slot (
        .clk       (clk),
        .rst       (rst),
        .char_done (char_done),
        .char_in   (char_data),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_word  (out_word)
    );

    // R1
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_word[9:8] == 2'b00));

endmodule

// File: tb/serial_rx_unit_tb.sv
module serial_rx_unit_tb;

    localparam int TICK_DIV = 4;
    localparam int BIT_CLK  = 16 * TICK_DIV;

    logic        clk = 1'b0;
    logic        rst;
    logic        os_tick;
    logic        rxd;
    logic        cfg_len8, cfg_par_en, cfg_par_odd, cfg_two_stop, cfg_rx_invert;
    logic [1:0]  cfg_idle_sel;
    logic        out_valid, out_ready;
    logic [15:0] out_word;
    logic        line_idle, idle_hit;
    logic [1:0]  tdiv;

    int          n_checks = 0;
    int          n_fail   = 0;
    bit          chk_busy = 0;
    logic [15:0] exp_q[$];

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (rst) begin
            tdiv    <= '0;
            os_tick <= 1'b0;
        end else begin
            tdiv    <= tdiv + 2'd1;
            os_tick <= (tdiv == 2'd3);
        end
    end

    serial_rx_unit u_dut (
        .clk           (clk),
        .rst           (rst),
        .os_tick       (os_tick),
        .rxd           (rxd),
        .cfg_len8      (cfg_len8),
        .cfg_par_en    (cfg_par_en),
        .cfg_par_odd   (cfg_par_odd),
        .cfg_two_stop  (cfg_two_stop),
        .cfg_idle_sel  (cfg_idle_sel),
        .cfg_rx_invert (cfg_rx_invert),
        .out_valid     (out_valid),
        .out_ready     (out_ready),
        .out_word      (out_word),
        .line_idle     (line_idle),
        .idle_hit      (idle_hit)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // Expected word from the requirements (R1-style layout, R6 summary)
    function automatic logic [15:0] exp_word(input logic [7:0] d_in, input bit flip,
                                             input logic [1:0] sb, input bit ovr);
        logic [7:0]  d;
        logic        pbit, perr, frm, brk;
        logic [15:0] w;
        d    = cfg_len8 ? d_in : {1'b0, d_in[6:0]};
        pbit = ^d ^ cfg_par_odd ^ flip;
        perr = cfg_par_en && flip;
        frm  = (sb != 2'd0);
        brk  = (sb == 2'd1) && (d == 8'h00) && (!cfg_par_en || !pbit);
        w     = '0;
        w[7:0] = d;
        w[10] = perr;
        w[11] = brk;
        w[12] = frm;
        w[13] = ovr;
        w[14] = perr | brk | frm | ovr;
        w[15] = 1'b1;
        return w;
    endfunction

    function automatic string tag_of(input logic [15:0] w);
        if (w[13]) return "R7";
        if (w[11]) return "R5";
        if (w[12]) return "R4";
        if (w[10]) return "R3";
        if (cfg_rx_invert) return "R10";
        return "R2/R1/R6";
    endfunction

    // Output monitor: compares every accepted word against the expected queue
    always @(negedge clk) begin
        if (!rst && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 unexpected character", {16'h0, out_word}, 32'h0);
            end else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                check(out_word == e, tag_of(e), {16'h0, out_word}, {16'h0, e});
            end
        end
    end

    task automatic send_bit(input logic b);
        @(negedge clk);
        rxd = b ^ cfg_rx_invert;
        repeat (BIT_CLK - 1) @(negedge clk);
    endtask

    task automatic wait_ticks(input int n);
        repeat (n * TICK_DIV) @(negedge clk);
    endtask

    // sb: 0 good stops, 1 first stop low, 2 second stop low (two-stop mode)
    task automatic send_frame(input logic [7:0] d_in, input bit flip, input logic [1:0] sb);
        logic [7:0] d;
        logic       pbit;
        d    = cfg_len8 ? d_in : {1'b0, d_in[6:0]};
        pbit = ^d ^ cfg_par_odd ^ flip;
        send_bit(1'b0);
        if (chk_busy) begin
            check(line_idle == 1'b0, "R11 busy", {31'h0, line_idle}, 32'h0);
            check(idle_hit == 1'b0, "R12 cleared", {31'h0, idle_hit}, 32'h0);
            chk_busy = 0;
        end
        for (int i = 0; i < (cfg_len8 ? 8 : 7); i++) send_bit(d[i]);
        if (cfg_par_en) send_bit(pbit);
        if (sb == 2'd1) begin
            send_bit(1'b0);
        end else begin
            send_bit(1'b1);
            if (cfg_two_stop) send_bit(sb == 2'd2 ? 1'b0 : 1'b1);
        end
        send_bit(1'b1);
        send_bit(1'b1);
    endtask

    task automatic set_cfg(input bit l8, input bit pe, input bit po, input bit ts,
                           input bit inv);
        @(negedge clk);
        cfg_len8      = l8;
        cfg_par_en    = pe;
        cfg_par_odd   = po;
        cfg_two_stop  = ts;
        cfg_rx_invert = inv;
        rxd           = 1'b1 ^ inv;
        wait_ticks(40);
    endtask

    task automatic drain();
        for (int i = 0; i < 2000 && exp_q.size() != 0; i++) @(negedge clk);
        check(exp_q.size() == 0, "R1 delivery", exp_q.size(), 32'h0);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired, requirement R1 actual=hung expected=done");
        finish_up();
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        rst = 1'b1; rxd = 1'b1; out_ready = 1'b1;
        cfg_len8 = 1'b1; cfg_par_en = 1'b0; cfg_par_odd = 1'b0;
        cfg_two_stop = 1'b0; cfg_rx_invert = 1'b0; cfg_idle_sel = 2'd0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state (R1, R11, R12)
        check(out_valid == 1'b0, "R1 reset valid", {31'h0, out_valid}, 32'h0);
        check(line_idle == 1'b1, "R11 reset idle", {31'h0, line_idle}, 32'h1);
        check(idle_hit == 1'b0, "R12 reset", {31'h0, idle_hit}, 32'h0);
        wait_ticks(40);

        // R9: short low glitch is rejected
        @(negedge clk); rxd = 1'b0;
        wait_ticks(3);
        @(negedge clk); rxd = 1'b1;
        wait_ticks(40);
        check(out_valid == 1'b0 && line_idle == 1'b1, "R9 glitch",
              {30'h0, out_valid, line_idle}, 32'h1);

        // R11 busy indication on a plain frame
        chk_busy = 1;
        exp_q.push_back(exp_word(8'hA5, 0, 2'd0, 0));
        send_frame(8'hA5, 0, 2'd0);
        drain();

        // R5: break with even parity and two stops
        set_cfg(1, 1, 0, 1, 0);
        exp_q.push_back(exp_word(8'h00, 0, 2'd1, 0));
        send_frame(8'h00, 0, 2'd1);
        drain();
        // R4: second stop missing
        exp_q.push_back(exp_word(8'h3C, 0, 2'd2, 0));
        send_frame(8'h3C, 0, 2'd2);
        drain();

        // R7, R8: overrun with a stalled consumer
        set_cfg(1, 0, 0, 0, 0);
        @(negedge clk); out_ready = 1'b0;
        send_frame(8'h11, 0, 2'd0);
        check(out_valid == 1'b1 && out_word == exp_word(8'h11, 0, 2'd0, 0), "R8 hold",
              {15'h0, out_valid, out_word}, {15'h0, 1'b1, exp_word(8'h11, 0, 2'd0, 0)});
        send_frame(8'h22, 0, 2'd0);
        check(out_word == exp_word(8'h11, 0, 2'd0, 0), "R8 stable after drop",
              {16'h0, out_word}, {16'h0, exp_word(8'h11, 0, 2'd0, 0)});
        exp_q.push_back(exp_word(8'h11, 0, 2'd0, 0));
        @(negedge clk); out_ready = 1'b1;
        drain();
        exp_q.push_back(exp_word(8'h33, 0, 2'd0, 1));
        send_frame(8'h33, 0, 2'd0);
        drain();
        exp_q.push_back(exp_word(8'h44, 0, 2'd0, 0));
        send_frame(8'h44, 0, 2'd0);
        drain();

        // R12: idle thresholds for codes 0 and 1
        for (int s = 0; s < 2; s++) begin
            int t;
            cfg_idle_sel = s[1:0];
            t = (4 << s) * (9 + 1) * 16;
            exp_q.push_back(exp_word(8'h5A, 0, 2'd0, 0));
            send_frame(8'h5A, 0, 2'd0);
            wait_ticks(t - 39 - 16);
            check(idle_hit == 1'b0, "R12 early", {31'h0, idle_hit}, 32'h0);
            wait_ticks(32);
            check(idle_hit == 1'b1, "R12 reached", {31'h0, idle_hit}, 32'h1);
            drain();
            chk_busy = 1;
            exp_q.push_back(exp_word(8'h0F, 0, 2'd0, 0));
            send_frame(8'h0F, 0, 2'd0);
            drain();
        end

        // Random traffic over configurations (R2, R3, R4, R5, R6, R10)
        for (int c = 0; c < 8; c++) begin
            set_cfg($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
                    $urandom_range(0, 1), (c >= 5));
            for (int k = 0; k < 14; k++) begin
                logic [7:0] d;
                bit         flip;
                logic [1:0] sb;
                d    = ($urandom_range(0, 7) == 0) ? 8'h00 : 8'($urandom);
                flip = cfg_par_en && ($urandom_range(0, 5) == 0);
                sb   = 2'd0;
                if ($urandom_range(0, 7) == 0) sb = 2'd1;
                else if (cfg_two_stop && $urandom_range(0, 7) == 0) sb = 2'd2;
                exp_q.push_back(exp_word(d, flip, sb, 0));
                send_frame(d, flip, sb);
            end
            drain();
        end

        finish_up();
    end

endmodule